// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block takes bytes from an IEEE 1284 peripheral that is sending in the ECP reverse direction, and it expands run-length-compressed data. A read request carries a byte count. If the port is not yet reversed, the block first turns the bus around. It then repeats a strobe/acknowledge handshake for each byte the peripheral presents on the 8-bit data bus. The busy line tells the block whether a byte is data or a command. A command byte either sets a repeat count for the next data byte or names a channel, and a channel command is dropped. Decoded bytes leave on a valid/ready stream. The request ends when the requested count has been delivered, when the peripheral stays silent too long, or when a handshake times out.

All handshake limits are counted in ticks, which come from a strobe input. A repeat count that is only partly used by one request stays pending and opens the next request. A separate forward request hands the bus back to the host. Every direction change throws away any pending repeats.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset the block is idle (idle_o=1). It drives autofd_n_o=1, init_n_o=1 and data_oe_o=1, and out_valid_o=0 and done_o=0.
- R2: The first read after reset drives autofd_n_o low with init_n_o still high. perror_i must then go high within RESP_TICKS ticks. If it does not, the request ends with status 2 (timeout) and autofd_n_o returns high.
- R3: A turnaround from forward to reverse drops autofd_n_o and data_oe_o in the same cycle. After SETUP_TICKS ticks it drives init_n_o low. perror_i must then go low within RESP_TICKS ticks, or the request ends with status 2.
- R4: A byte strobed with ack_n_i low while busy_i is high is data. It appears exactly once on the stream.
- R5: A byte strobed while busy_i is low is a command. When bit 7 is 1 it is a channel address, is discarded and puts nothing on the stream.
- R6: A command with bit 7 = 0 holds a count N in bits 6:0. The next data byte is delivered once and then repeated N more times.
- R7: Repeats stop as soon as the requested count is reached. Those left over are delivered at the start of the next read, before any bus handshake.
- R8: After each byte is taken (for data: once the stream accepts it), autofd_n_o goes high. ack_n_i must rise within RESP_TICKS ticks, and autofd_n_o then returns low. If ack_n_i does not rise in time, the request ends with status 2 and autofd_n_o returns low.
- R9: If no strobe arrives within IDLE_TICKS ticks while bytes are still owed, the request ends with status 1 (idle end).
- R10: A forward request while reversed drives init_n_o high and waits up to RESP_TICKS ticks for perror_i high. It then drives autofd_n_o and data_oe_o high and reports status 0, or status 2 if perror_i never rose.
- R11: Every direction change clears any pending repeat count and the flag that waits for a byte to repeat.
- R12: out_data_o holds steady while out_valid_o is high and out_ready_i is low. Pending repeats go out one per clock while out_ready_i is high.
- R13: done_o is a single-cycle pulse. done_status_o is 0 when the count is reached. Requests that arrive while idle_o is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle timing tick used for all handshake limits |
| rd_req_i | input | 1 | Start a read (taken only when idle) |
| rd_len_i | input | CNT_W | Number of bytes the read should deliver |
| fwd_req_i | input | 1 | Turn the bus back to forward (taken only when idle) |
| idle_o | output | 1 | Block is ready for a new request |
| done_o | output | 1 | One-cycle pulse when a request ends |
| done_status_o | output | 2 | 0 count reached / turnaround done, 1 idle end, 2 timeout |
| pd_i | input | 8 | Peripheral data bus |
| ack_n_i | input | 1 | Peripheral strobe, low when a byte is present |
| busy_i | input | 1 | High marks a data byte, low a command byte |
| perror_i | input | 1 | Peripheral turnaround acknowledge |
| autofd_n_o | output | 1 | Host acknowledge line |
| init_n_o | output | 1 | Host direction request, low for reverse |
| data_oe_o | output | 1 | Host data driver enable |
| out_valid_o | output | 1 | Stream byte valid |
| out_data_o | output | 8 | Stream byte |
| out_ready_i | input | 1 | Stream consumer ready |

## Verification
The assertions check four things on every cycle. While a stream byte is offered, all three host lines stay in the reverse-receive state. The data drivers are off whenever a reverse is requested. A stalled stream byte stays steady. Each raise of the acknowledge in reverse follows a cycle with the strobe low. The run store is also checked never to be drained while it is empty or still waiting for its byte. Only the bench scenarios can show that command bytes are told apart correctly, that repeats carry over between requests and are dropped on a direction change, and that each timeout produces its own status after the right number of ticks.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

    // Width of the run count carried in a command byte (bits 6:0)
    localparam int RUN_W = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ENTRY,
        S_TURN_SETUP,
        S_TURN_WAIT,
        S_NEXT,
        S_EXPAND,
        S_WAIT,
        S_PUSH,
        S_ACK,
        S_FWD
    } rx_state_e;

    typedef enum logic [1:0] {
        LK_ENTRY,
        LK_FWD,
        LK_REV
    } link_e;

    typedef enum logic [1:0] {
        XS_OK   = 2'd0,
        XS_IDLE = 2'd1,
        XS_TMO  = 2'd2
    } xfer_stat_e;

endpackage

// File: rtl/ecp_tick_timer.sv
module ecp_tick_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic [TW-1:0] limit_i,
    output logic          expired_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (tick_i && !(&cnt_q))
            cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q >= limit_i);

    // R8: a freshly cleared window never reads as expired
    clr_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!expired_o || limit_i == '0));

endmodule

// File: rtl/ecp_cmd_decode.sv
module ecp_cmd_decode
    import ecp_rx_pkg::*;
(
    input  logic [7:0]       byte_i,
    input  logic             busy_i,
    output logic             is_data_o,
    output logic             is_run_o,
    output logic [RUN_W-1:0] run_len_o
);

    always_comb begin
        is_data_o = busy_i;
        is_run_o  = !busy_i && !byte_i[7];
        run_len_o = byte_i[RUN_W-1:0];
    end

endmodule

// File: rtl/ecp_run_store.sv
module ecp_run_store
    import ecp_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             load_i,
    input  logic [RUN_W-1:0] load_len_i,
    input  logic             capture_i,
    input  logic [7:0]       capture_byte_i,
    input  logic             consume_i,
    output logic [RUN_W-1:0] run_cnt_o,
    output logic             run_wait_o,
    output logic [7:0]       rep_byte_o
);

    typedef struct packed {
        logic [RUN_W-1:0] cnt;
        logic             wait_byte;
        logic [7:0]       rep;
    } run_t;

    run_t d, q;

    always_comb begin
        d = q;
        if (clr_i) begin
            d.cnt       = '0;
            d.wait_byte = 1'b0;
        end else if (load_i) begin
            d.cnt       = load_len_i;
            d.wait_byte = 1'b1;
        end else if (capture_i && q.wait_byte) begin
            d.rep       = capture_byte_i;
            d.wait_byte = 1'b0;
        end else if (consume_i) begin
            d.cnt       = q.cnt - RUN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, wait_byte: 1'b0, rep: '0};
        else        q <= d;
    end

    assign run_cnt_o  = q.cnt;
    assign run_wait_o = q.wait_byte;
    assign rep_byte_o = q.rep;

    // R6
    no_empty_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |-> (q.cnt != '0 && !q.wait_byte));

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
    import ecp_rx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SETUP_TICKS = 1,
    parameter int RESP_TICKS  = 6,
    parameter int IDLE_TICKS  = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             rd_req_i,
    input  logic [CNT_W-1:0] rd_len_i,
    input  logic             fwd_req_i,
    output logic             idle_o,
    output logic             done_o,
    output logic [1:0]       done_status_o,
    input  logic [7:0]       pd_i,
    input  logic             ack_n_i,
    input  logic             busy_i,
    input  logic             perror_i,
    output logic             autofd_n_o,
    output logic             init_n_o,
    output logic             data_oe_o,
    output logic             out_valid_o,
    output logic [7:0]       out_data_o,
    input  logic             out_ready_i
);

    localparam int TW = $clog2(IDLE_TICKS + RESP_TICKS + SETUP_TICKS + 2);
    localparam logic [TW-1:0] LIM_SETUP = TW'(SETUP_TICKS);
    localparam logic [TW-1:0] LIM_RESP  = TW'(RESP_TICKS);
    localparam logic [TW-1:0] LIM_IDLE  = TW'(IDLE_TICKS);

    typedef struct packed {
        rx_state_e  st;
        link_e      link;
        logic       autofd_n;
        logic       init_n;
        logic       oe;
        logic [CNT_W-1:0] rem;
        logic [7:0] hold;
        logic       done;
        xfer_stat_e stat;
    } ctl_t;

    ctl_t d, q;

    logic             tmr_clr, tmr_exp;
    logic [TW-1:0]    tmr_lim;
    logic             is_data, is_run;
    logic [RUN_W-1:0] cmd_len;
    logic             rs_clr, rs_load, rs_capture, rs_consume;
    logic [RUN_W-1:0] run_cnt;
    logic             run_wait;
    logic [7:0]       rep_byte;

    ecp_tick_timer #(.TW(TW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (tmr_clr),
        .tick_i    (tick_i),
        .limit_i   (tmr_lim),
        .expired_o (tmr_exp)
    );

    ecp_cmd_decode u_decode (
        .byte_i    (pd_i),
        .busy_i    (busy_i),
        .is_data_o (is_data),
        .is_run_o  (is_run),
        .run_len_o (cmd_len)
    );

    ecp_run_store u_runs (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_i          (rs_clr),
        .load_i         (rs_load),
        .load_len_i     (cmd_len),
        .capture_i      (rs_capture),
        .capture_byte_i (q.hold),
        .consume_i      (rs_consume),
        .run_cnt_o      (run_cnt),
        .run_wait_o     (run_wait),
        .rep_byte_o     (rep_byte)
    );

    // Limit of the wait window that belongs to the current state
    always_comb begin
        unique case (q.st)
            S_TURN_SETUP: tmr_lim = LIM_SETUP;
            S_WAIT:       tmr_lim = LIM_IDLE;
            default:      tmr_lim = LIM_RESP;
        endcase
    end

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        rs_clr     = 1'b0;
        rs_load    = 1'b0;
        rs_capture = 1'b0;
        rs_consume = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (rd_req_i) begin
                    d.rem = rd_len_i;
                    unique case (q.link)
                        LK_ENTRY: begin
                            d.autofd_n = 1'b0;
                            d.st       = S_ENTRY;
                        end
                        LK_FWD: begin
                            d.autofd_n = 1'b0;
                            d.oe       = 1'b0;
                            rs_clr     = 1'b1;
                            d.st       = S_TURN_SETUP;
                        end
                        default: d.st = S_NEXT;
                    endcase
                end else if (fwd_req_i) begin
                    if (q.link == LK_REV) begin
                        d.init_n = 1'b1;
                        d.st     = S_FWD;
                    end else begin
                        d.done = 1'b1;
                        d.stat = XS_OK;
                    end
                end
            end
            S_ENTRY: begin
                if (perror_i) begin
                    d.oe   = 1'b0;
                    d.link = LK_FWD;
                    rs_clr = 1'b1;
                    d.st   = S_TURN_SETUP;
                end else if (tmr_exp) begin
                    d.autofd_n = 1'b1;
                    d.done     = 1'b1;
                    d.stat     = XS_TMO;
                    d.st       = S_IDLE;
                end
            end
            S_TURN_SETUP: begin
                if (tmr_exp) begin
                    d.init_n = 1'b0;
                    d.link   = LK_REV;
                    d.st     = S_TURN_WAIT;
                end
            end
            S_TURN_WAIT: begin
                if (!perror_i) begin
                    d.st = S_NEXT;
                end else if (tmr_exp) begin
                    d.done = 1'b1;
                    d.stat = XS_TMO;
                    d.st   = S_IDLE;
                end
            end
            S_NEXT: begin
                if (q.rem == '0) begin
                    d.done = 1'b1;
                    d.stat = XS_OK;
                    d.st   = S_IDLE;
                end else if (run_cnt != '0 && !run_wait) begin
                    d.st = S_EXPAND;
                end else begin
                    d.st = S_WAIT;
                end
            end
            S_EXPAND: begin
                if (out_ready_i) begin
                    rs_consume = 1'b1;
                    d.rem      = q.rem - CNT_W'(1);
                    if (q.rem == CNT_W'(1) || run_cnt == RUN_W'(1))
                        d.st = S_NEXT;
                end
            end
            S_WAIT: begin
                if (!ack_n_i) begin
                    d.hold = pd_i;
                    if (is_data) begin
                        d.st = S_PUSH;
                    end else begin
                        rs_load    = is_run;
                        d.autofd_n = 1'b1;
                        d.st       = S_ACK;
                    end
                end else if (tmr_exp) begin
                    d.done = 1'b1;
                    d.stat = XS_IDLE;
                    d.st   = S_IDLE;
                end
            end
            S_PUSH: begin
                if (out_ready_i) begin
                    d.rem      = q.rem - CNT_W'(1);
                    rs_capture = 1'b1;
                    d.autofd_n = 1'b1;
                    d.st       = S_ACK;
                end
            end
            S_ACK: begin
                if (ack_n_i) begin
                    d.autofd_n = 1'b0;
                    d.st       = S_NEXT;
                end else if (tmr_exp) begin
                    d.autofd_n = 1'b0;
                    d.done     = 1'b1;
                    d.stat     = XS_TMO;
                    d.st       = S_IDLE;
                end
            end
            S_FWD: begin
                if (perror_i || tmr_exp) begin
                    d.autofd_n = 1'b1;
                    d.oe       = 1'b1;
                    d.link     = LK_FWD;
                    rs_clr     = 1'b1;
                    d.done     = 1'b1;
                    d.stat     = perror_i ? XS_OK : XS_TMO;
                    d.st       = S_IDLE;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    assign tmr_clr = (d.st != q.st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '{st: S_IDLE, link: LK_ENTRY, autofd_n: 1'b1, init_n: 1'b1,
                   oe: 1'b1, rem: '0, hold: '0, done: 1'b0, stat: XS_OK};
        else
            q <= d;
    end

    assign idle_o        = (q.st == S_IDLE);
    assign done_o        = q.done;
    assign done_status_o = q.stat;
    assign autofd_n_o    = q.autofd_n;
    assign init_n_o      = q.init_n;
    assign data_oe_o     = q.oe;
    assign out_valid_o   = (q.st == S_EXPAND) || (q.st == S_PUSH);
    assign out_data_o    = (q.st == S_EXPAND) ? rep_byte : q.hold;

    // R4
    rx_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (!autofd_n_o && !init_n_o && !data_oe_o));

    // R3
    drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_n_o |-> !data_oe_o);

    // R12
    stream_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

    // R8
    ack_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(autofd_n_o) && !init_n_o) |-> $past(!ack_n_i));

    // R13
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: tb/ecp_rev_rx_bench.sv
module ecp_rev_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int WD_LIMIT   = 120000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_i = 1'b0;
    logic             rd_req_i = 1'b0;
    logic [CNT_W-1:0] rd_len_i = '0;
    logic             fwd_req_i = 1'b0;
    logic             idle_o, done_o;
    logic [1:0]       done_status_o;
    logic [7:0]       pd_i = 8'h00;
    logic             ack_n_i = 1'b1;
    logic             busy_i = 1'b0;
    logic             perror_i;
    logic             autofd_n_o, init_n_o, data_oe_o;
    logic             out_valid_o;
    logic [7:0]       out_data_o;
    logic             out_ready_i = 1'b1;

    logic             resp_en = 1'b0;
    logic             pe_force = 1'b0;
    logic [1:0]       pe_sh = 2'b11;
    logic [1:0]       div = 2'd0;

    int checks = 0, errors = 0, cyc = 0;
    logic [7:0] rx_dat [0:63];
    int rx_cyc [0:63];
    int rx_n = 0;
    int done_cnt = 0, done_cyc = 0, last_stat = 0, req_cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // peripheral model: answers a direction request two cycles later
    always @(posedge clk) pe_sh <= {pe_sh[0], init_n_o};
    assign perror_i = resp_en ? pe_sh[1] : pe_force;

    always @(posedge clk) begin
        div    <= div + 2'd1;
        tick_i <= (div == 2'd3);
    end

    ecp_rev_rx #(.CNT_W(CNT_W)) u_ecp_rev_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
        .rd_req_i(rd_req_i), .rd_len_i(rd_len_i), .fwd_req_i(fwd_req_i),
        .idle_o(idle_o), .done_o(done_o), .done_status_o(done_status_o),
        .pd_i(pd_i), .ack_n_i(ack_n_i), .busy_i(busy_i), .perror_i(perror_i),
        .autofd_n_o(autofd_n_o), .init_n_o(init_n_o), .data_oe_o(data_oe_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (out_valid_o && out_ready_i && rx_n < 64) begin
            rx_dat[rx_n] = out_data_o;
            rx_cyc[rx_n] = cyc;
            rx_n = rx_n + 1;
        end
        if (done_o) begin
            done_cnt  = done_cnt + 1;
            done_cyc  = cyc;
            last_stat = int'(done_status_o);
        end
        if (cyc > WD_LIMIT) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act=%0d exp<=%0d cycles", cyc, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_rng(input string req, input int act, input int lo, input int hi);
        checks = checks + 1;
        if (act < lo || act > hi) begin
            errors = errors + 1;
            $display("FAIL %s: act=%0d exp=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic start_read(input int len);
        rx_n = 0;
        step();
        rd_req_i = 1'b1;
        rd_len_i = CNT_W'(len);
        req_cyc  = cyc;
        step();
        rd_req_i = 1'b0;
    endtask

    task automatic start_fwd();
        step();
        fwd_req_i = 1'b1;
        req_cyc   = cyc;
        step();
        fwd_req_i = 1'b0;
    endtask

    task automatic wait_done(input int seen);
        while (done_cnt == seen) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic is_dat, input bit raise);
        do @(negedge clk); while (!(autofd_n_o == 1'b0 && init_n_o == 1'b0 && perror_i == 1'b0));
        step();
        pd_i = b; busy_i = is_dat; ack_n_i = 1'b0;
        do @(negedge clk); while (autofd_n_o != 1'b1);
        if (raise) begin
            step();
            ack_n_i = 1'b1;
            do @(negedge clk); while (autofd_n_o != 1'b0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 idle", int'(idle_o), 1);
        chk("R1 autofd", int'(autofd_n_o), 1);
        chk("R1 init", int'(init_n_o), 1);
        chk("R1 oe", int'(data_oe_o), 1);
        chk("R1 valid", int'(out_valid_o), 0);
        chk("R1 done", int'(done_o), 0);
    endtask

    task automatic t_entry_timeout();
        int seen;
        seen = done_cnt;
        resp_en = 1'b0; pe_force = 1'b0;
        start_read(1);
        @(negedge clk);
        chk("R2 autofd low", int'(autofd_n_o), 0);
        chk("R2 init high", int'(init_n_o), 1);
        wait_done(seen);
        chk("R2 status", last_stat, 2);
        chk_rng("R2 window", done_cyc - req_cyc, 16, 34);
        @(negedge clk);
        chk("R2 autofd back", int'(autofd_n_o), 1);
    endtask

    task automatic t_data_and_channel();
        int seen;
        seen = done_cnt;
        resp_en = 1'b1;
        start_read(3);
        send_byte(8'h11, 1'b1, 1'b1);
        send_byte(8'hA5, 1'b0, 1'b1);
        send_byte(8'h22, 1'b1, 1'b1);
        send_byte(8'h33, 1'b1, 1'b1);
        wait_done(seen);
        chk("R13 status ok", last_stat, 0);
        chk("R5 count", rx_n, 3);
        chk("R4 b0", int'(rx_dat[0]), 'h11);
        chk("R5 b1", int'(rx_dat[1]), 'h22);
        chk("R4 b2", int'(rx_dat[2]), 'h33);
    endtask

    task automatic t_run_expand();
        int seen;
        seen = done_cnt;
        start_read(5);
        send_byte(8'h03, 1'b0, 1'b1);
        send_byte(8'h7E, 1'b1, 1'b1);
        send_byte(8'h44, 1'b1, 1'b1);
        wait_done(seen);
        chk("R6 count", rx_n, 5);
        for (int i = 0; i < 4; i++) chk("R6 repeat", int'(rx_dat[i]), 'h7E);
        chk("R6 tail", int'(rx_dat[4]), 'h44);
    endtask

    task automatic t_run_carry();
        int seen;
        seen = done_cnt;
        start_read(2);
        send_byte(8'h04, 1'b0, 1'b1);
        send_byte(8'h5A, 1'b1, 1'b1);
        wait_done(seen);
        chk("R7 first count", rx_n, 2);
        chk("R7 first repeat", int'(rx_dat[1]), 'h5A);
        seen = done_cnt;
        start_read(4);
        do @(negedge clk); while (rx_n < 3);
        chk("R7 no strobe", int'(ack_n_i), 1);
        chk("R7 carry 2", int'(rx_dat[2]), 'h5A);
        chk("R12 per clock a", rx_cyc[1] - rx_cyc[0], 1);
        chk("R12 per clock b", rx_cyc[2] - rx_cyc[1], 1);
        send_byte(8'h66, 1'b1, 1'b1);
        wait_done(seen);
        chk("R7 second count", rx_n, 4);
        chk("R7 fresh", int'(rx_dat[3]), 'h66);
    endtask

    task automatic t_stall();
        int seen;
        logic [7:0] held;
        seen = done_cnt;
        out_ready_i = 1'b0;
        start_read(1);
        fork
            send_byte(8'hC3, 1'b1, 1'b1);
            begin
                do @(negedge clk); while (!out_valid_o);
                held = out_data_o;
                for (int i = 0; i < 5; i++) begin
                    @(negedge clk);
                    chk("R12 valid held", int'(out_valid_o), 1);
                    chk("R12 data held", int'(out_data_o), int'(held));
                    chk("R8 no early ack", int'(autofd_n_o), 0);
                end
                step();
                out_ready_i = 1'b1;
            end
        join
        wait_done(seen);
        chk("R4 stalled byte", int'(rx_dat[0]), 'hC3);
    endtask

    task automatic t_ack_timeout();
        int seen;
        seen = done_cnt;
        start_read(1);
        send_byte(8'hB1, 1'b1, 1'b0);
        wait_done(seen);
        chk("R8 status", last_stat, 2);
        chk("R8 byte", int'(rx_dat[0]), 'hB1);
        @(negedge clk);
        chk("R8 autofd low", int'(autofd_n_o), 0);
        step();
        ack_n_i = 1'b1;
    endtask

    task automatic t_busy_ignore();
        int seen;
        seen = done_cnt;
        start_read(1);
        step();
        fwd_req_i = 1'b1;
        @(negedge clk);
        chk("R13 busy", int'(idle_o), 0);
        step();
        fwd_req_i = 1'b0;
        send_byte(8'h77, 1'b1, 1'b1);
        wait_done(seen);
        repeat (4) @(negedge clk);
        chk("R13 one done", done_cnt - seen, 1);
        chk("R13 still reverse", int'(init_n_o), 0);
        chk("R13 byte", int'(rx_dat[0]), 'h77);
    endtask

    task automatic t_idle_end();
        int seen;
        seen = done_cnt;
        start_read(2);
        wait_done(seen);
        chk("R9 status", last_stat, 1);
        chk_rng("R9 window", done_cyc - req_cyc, 7950, 8100);
    endtask

    task automatic t_forward_clears();
        int seen, t0;
        seen = done_cnt;
        start_read(1);
        send_byte(8'h05, 1'b0, 1'b1);
        send_byte(8'h99, 1'b1, 1'b1);
        wait_done(seen);
        chk("R6 single", int'(rx_dat[0]), 'h99);
        seen = done_cnt;
        start_fwd();
        wait_done(seen);
        @(negedge clk);
        chk("R10 status", last_stat, 0);
        chk("R10 init", int'(init_n_o), 1);
        chk("R10 autofd", int'(autofd_n_o), 1);
        chk("R10 oe", int'(data_oe_o), 1);
        seen = done_cnt;
        start_read(2);
        do @(negedge clk); while (autofd_n_o != 1'b0);
        chk("R3 oe off", int'(data_oe_o), 0);
        t0 = cyc;
        do @(negedge clk); while (init_n_o != 1'b0);
        chk_rng("R3 setup", cyc - t0, 1, 5);
        send_byte(8'h12, 1'b1, 1'b1);
        send_byte(8'h34, 1'b1, 1'b1);
        wait_done(seen);
        chk("R11 count", rx_n, 2);
        chk("R11 b0", int'(rx_dat[0]), 'h12);
        chk("R11 b1", int'(rx_dat[1]), 'h34);
    endtask

    task automatic t_forward_timeout();
        int seen;
        seen = done_cnt;
        resp_en = 1'b0; pe_force = 1'b0;
        start_fwd();
        wait_done(seen);
        @(negedge clk);
        chk("R10 tmo status", last_stat, 2);
        chk("R10 tmo oe", int'(data_oe_o), 1);
        chk("R10 tmo autofd", int'(autofd_n_o), 1);
    endtask

    task automatic t_turn_timeout();
        int seen;
        seen = done_cnt;
        resp_en = 1'b0; pe_force = 1'b1;
        start_read(1);
        wait_done(seen);
        @(negedge clk);
        chk("R3 tmo status", last_stat, 2);
        chk("R3 tmo init", int'(init_n_o), 0);
        chk("R3 tmo oe", int'(data_oe_o), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_entry_timeout();
        t_data_and_channel();
        t_run_expand();
        t_run_carry();
        t_stall();
        t_ack_timeout();
        t_busy_ignore();
        t_idle_end();
        t_forward_clears();
        t_forward_timeout();
        t_turn_timeout();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule